// File: doc/BRIEF.md
# AXI Transaction ID Remapper

This block joins an upstream AXI port that uses wide transaction IDs to a downstream port whose IDs are narrower. Each upstream ID that currently has transactions in flight is bound to a downstream ID of its own. Two requests that could be reordered upstream therefore stay reorderable downstream. When a B response or an R beat returns, the block uses the downstream ID as a table index and puts the original upstream ID back on the beat.

Writes and reads are tracked in two separate remap tables. Each table entry is a two-state machine, `ENT_FREE` or `ENT_LIVE`, and holds an upstream ID and an outstanding-transaction counter. A request that names a new upstream ID takes the free entry with the lowest index. It moves that entry from `ENT_FREE` to `ENT_LIVE` with a count of one. A request whose upstream ID is already live reuses that entry and increments its count. A B response, or an R beat with last set, decrements the count of the entry it names. When the count reaches zero, the entry returns from `ENT_LIVE` to `ENT_FREE`. If a push and a retirement hit the same entry in the same cycle, the count is unchanged and the entry stays `ENT_LIVE`. Atomic writes that also produce read data take an entry in both tables, and both entries use the same index. Write data passes straight through.

Top module: `idr_remap`

## Requirements
- R1: After an asynchronous active-low reset, both tables are empty and no forwarded valid is raised while the upstream side is idle. The first write request afterwards is sent with downstream ID 0.
- R2: A request with an upstream ID that is not live takes the lowest-index free entry. That index, zero-extended, becomes the downstream ID.
- R3: A request whose upstream ID is live reuses the same downstream ID. Distinct live upstream IDs never share a downstream ID within one table.
- R4: Each B response and each R beat is returned upstream carrying the upstream ID held in the entry named by its downstream ID. Response code and read data pass through unchanged.
- R5: A B response, or an R beat with last set, decrements the count of its entry, and the entry is freed when the count reaches zero. An R beat without last leaves the count unchanged.
- R6: When the entry for the requested upstream ID already holds MAX_TXN transactions, the request is stalled. The downstream valid and upstream ready stay low, and the request goes out in the cycle after a response retires one of that ID's transactions.
- R7: A request with a new upstream ID stalls while every entry is live. A retirement that frees an entry during a stall cycle does not release the request in that same cycle. The request goes out on the following cycle, using the freed index.
- R8: Read requests allocate from the read table, independently of the write table.
- R9: A write request with atomic-op bit 5 set (`aw_atop[5]=1`, meaning read data also returns) takes an entry in both tables at one shared index. It stalls until both tables can accept it there. A request with bit 5 clear uses only the write table.
- R10: While a write request with atop bit 5 set is valid upstream, read requests are held off (downstream valid and upstream ready low).
- R11: Write data beats (data, last, valid and ready) pass through unchanged.
- R12: An address request is forwarded only in a cycle where its table update can commit. Upstream ready is then equal to downstream ready, and otherwise both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_aw_valid | input | 1 | Upstream write address valid |
| s_aw_ready | output | 1 | Upstream write address ready |
| s_aw_id | input | UP_ID_W | Upstream write ID |
| s_aw_addr | input | ADDR_W | Write address |
| s_aw_len | input | LEN_W | Write burst length |
| s_aw_atop | input | 6 | Atomic-operation code |
| m_aw_valid | output | 1 | Downstream write address valid |
| m_aw_ready | input | 1 | Downstream write address ready |
| m_aw_id | output | DN_ID_W | Downstream write ID |
| m_aw_addr | output | ADDR_W | Forwarded write address |
| m_aw_len | output | LEN_W | Forwarded burst length |
| m_aw_atop | output | 6 | Forwarded atomic code |
| s_w_valid | input | 1 | Upstream write data valid |
| s_w_ready | output | 1 | Upstream write data ready |
| s_w_data | input | DATA_W | Write data |
| s_w_last | input | 1 | Last write beat |
| m_w_valid | output | 1 | Downstream write data valid |
| m_w_ready | input | 1 | Downstream write data ready |
| m_w_data | output | DATA_W | Forwarded write data |
| m_w_last | output | 1 | Forwarded last flag |
| m_b_valid | input | 1 | Downstream write response valid |
| m_b_ready | output | 1 | Downstream write response ready |
| m_b_id | input | DN_ID_W | Downstream write response ID |
| m_b_resp | input | 2 | Write response code |
| s_b_valid | output | 1 | Upstream write response valid |
| s_b_ready | input | 1 | Upstream write response ready |
| s_b_id | output | UP_ID_W | Restored write response ID |
| s_b_resp | output | 2 | Forwarded response code |
| s_ar_valid | input | 1 | Upstream read address valid |
| s_ar_ready | output | 1 | Upstream read address ready |
| s_ar_id | input | UP_ID_W | Upstream read ID |
| s_ar_addr | input | ADDR_W | Read address |
| s_ar_len | input | LEN_W | Read burst length |
| m_ar_valid | output | 1 | Downstream read address valid |
| m_ar_ready | input | 1 | Downstream read address ready |
| m_ar_id | output | DN_ID_W | Downstream read ID |
| m_ar_addr | output | ADDR_W | Forwarded read address |
| m_ar_len | output | LEN_W | Forwarded read length |
| m_r_valid | input | 1 | Downstream read data valid |
| m_r_ready | output | 1 | Downstream read data ready |
| m_r_id | input | DN_ID_W | Downstream read ID |
| m_r_data | input | DATA_W | Read data |
| m_r_resp | input | 2 | Read response code |
| m_r_last | input | 1 | Last read beat |
| s_r_valid | output | 1 | Upstream read data valid |
| s_r_ready | input | 1 | Upstream read data ready |
| s_r_id | output | UP_ID_W | Restored read ID |
| s_r_data | output | DATA_W | Forwarded read data |
| s_r_resp | output | 2 | Forwarded read response code |
| s_r_last | output | 1 | Forwarded last flag |

## Verification
Two functions can fall in the same cycle. A response can retire the last transaction of an entry while a new request waits for that entry, and an atomic write can compete with a read request for the read table. The first case is provoked by filling the write table with four IDs, holding a fifth ID valid, and returning the B of the third entry in that same cycle. The expected result is a stall in that cycle, the restored ID on the B channel, and the fifth request forwarded on the next cycle with downstream ID 2. The second case is provoked by raising an atomic write and a read request together. The expected result is that only the write goes out and the read is held off.

// File: rtl/idr_pkg.sv
package idr_pkg;

    // Lifecycle of one remap table slot
    typedef enum logic {
        ENT_FREE = 1'b0,
        ENT_LIVE = 1'b1
    } ent_state_e;

endpackage

// File: rtl/idr_pick.sv
// Lowest-index-first priority encoder over a request vector
module idr_pick #(
    parameter int N    = 4,
    parameter int IDXW = 2
) (
    input  logic [N-1:0]    req,
    output logic [IDXW-1:0] idx,
    output logic            any
);

    always_comb begin
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDXW'(i);
        end
    end

endmodule

// File: rtl/idr_table.sv
// One remap table: per-entry state machine, stored upstream ID and counter
module idr_table
    import idr_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int UP_W    = 6,
    parameter int MAX_TXN = 3,
    parameter int IDXW    = 2,
    parameter int CNTW    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [UP_W-1:0]    q_id,
    output logic [ENTRIES-1:0] match_vec,
    output logic [ENTRIES-1:0] free_vec,
    output logic [ENTRIES-1:0] sat_vec,
    input  logic               push_en,
    input  logic [IDXW-1:0]    push_idx,
    input  logic [UP_W-1:0]    push_id,
    input  logic               pop_en,
    input  logic [IDXW-1:0]    pop_idx,
    output logic [UP_W-1:0]    pop_up_id
);

    logic [UP_W-1:0] id_arr [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        ent_state_e      st_q, st_d;
        logic [UP_W-1:0] id_q, id_d;
        logic [CNTW-1:0] cnt_q, cnt_d;
        logic            push_i, pop_i;

        assign push_i = push_en && (push_idx == IDXW'(g));
        assign pop_i  = pop_en  && (pop_idx  == IDXW'(g));

        // next-state process
        always_comb begin
            st_d  = st_q;
            id_d  = id_q;
            cnt_d = cnt_q;
            unique case (st_q)
                ENT_FREE: begin
                    if (push_i) begin
                        st_d  = ENT_LIVE;
                        id_d  = push_id;
                        cnt_d = CNTW'(1);
                    end
                end
                ENT_LIVE: begin
                    cnt_d = cnt_q + CNTW'(push_i) - CNTW'(pop_i);
                    if (cnt_d == '0) st_d = ENT_FREE;
                end
                default: st_d = ENT_FREE;
            endcase
        end

        // state register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q  <= ENT_FREE;
                id_q  <= '0;
                cnt_q <= '0;
            end else begin
                st_q  <= st_d;
                id_q  <= id_d;
                cnt_q <= cnt_d;
            end
        end

        // outputs
        assign match_vec[g] = (st_q == ENT_LIVE) && (id_q == q_id);
        assign free_vec[g]  = (st_q == ENT_FREE);
        assign sat_vec[g]   = (cnt_q >= CNTW'(MAX_TXN));
        assign id_arr[g]    = id_q;
    end

    always_comb begin
        pop_up_id = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (pop_idx == IDXW'(i)) pop_up_id = id_arr[i];
        end
    end

endmodule

// File: rtl/idr_remap.sv
module idr_remap #(
    parameter int UP_ID_W = 6,
    parameter int DN_ID_W = 2,
    parameter int ENTRIES = 4,
    parameter int MAX_TXN = 3,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_aw_valid,
    output logic               s_aw_ready,
    input  logic [UP_ID_W-1:0] s_aw_id,
    input  logic [ADDR_W-1:0]  s_aw_addr,
    input  logic [LEN_W-1:0]   s_aw_len,
    input  logic [5:0]         s_aw_atop,
    output logic               m_aw_valid,
    input  logic               m_aw_ready,
    output logic [DN_ID_W-1:0] m_aw_id,
    output logic [ADDR_W-1:0]  m_aw_addr,
    output logic [LEN_W-1:0]   m_aw_len,
    output logic [5:0]         m_aw_atop,
    input  logic               s_w_valid,
    output logic               s_w_ready,
    input  logic [DATA_W-1:0]  s_w_data,
    input  logic               s_w_last,
    output logic               m_w_valid,
    input  logic               m_w_ready,
    output logic [DATA_W-1:0]  m_w_data,
    output logic               m_w_last,
    input  logic               m_b_valid,
    output logic               m_b_ready,
    input  logic [DN_ID_W-1:0] m_b_id,
    input  logic [1:0]         m_b_resp,
    output logic               s_b_valid,
    input  logic               s_b_ready,
    output logic [UP_ID_W-1:0] s_b_id,
    output logic [1:0]         s_b_resp,
    input  logic               s_ar_valid,
    output logic               s_ar_ready,
    input  logic [UP_ID_W-1:0] s_ar_id,
    input  logic [ADDR_W-1:0]  s_ar_addr,
    input  logic [LEN_W-1:0]   s_ar_len,
    output logic               m_ar_valid,
    input  logic               m_ar_ready,
    output logic [DN_ID_W-1:0] m_ar_id,
    output logic [ADDR_W-1:0]  m_ar_addr,
    output logic [LEN_W-1:0]   m_ar_len,
    input  logic               m_r_valid,
    output logic               m_r_ready,
    input  logic [DN_ID_W-1:0] m_r_id,
    input  logic [DATA_W-1:0]  m_r_data,
    input  logic [1:0]         m_r_resp,
    input  logic               m_r_last,
    output logic               s_r_valid,
    input  logic               s_r_ready,
    output logic [UP_ID_W-1:0] s_r_id,
    output logic [DATA_W-1:0]  s_r_data,
    output logic [1:0]         s_r_resp,
    output logic               s_r_last
);

    localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNTW = $clog2(MAX_TXN + 1);

    // table status vectors
    logic [ENTRIES-1:0] w_match, w_free, w_sat;
    logic [ENTRIES-1:0] r_match, r_free, r_sat;
    logic [ENTRIES-1:0] both_free;

    logic [IDXW-1:0] wm_idx, wf_idx, rm_idx, rf_idx, bf_idx;
    logic            w_hit, w_any_free, r_hit, r_any_free, b_any_free;

    // request side decisions
    logic            aw_atom, aw_atom_req;
    logic [IDXW-1:0] w_idx, a_idx, aw_idx, r_idx;
    logic            w_ok, a_ok, aw_ok, r_ok;
    logic            aw_fire, ar_fire;

    // table ports
    logic [UP_ID_W-1:0] rt_q_id, rt_push_id, wt_up_id, rt_up_id;
    logic               rt_push_en, wt_pop_en, rt_pop_en;
    logic [IDXW-1:0]    rt_push_idx;

    assign aw_atom     = s_aw_atop[5];
    assign aw_atom_req = s_aw_valid && aw_atom;
    assign rt_q_id     = aw_atom_req ? s_aw_id : s_ar_id;
    assign both_free   = w_free & r_free;

    idr_table #(
        .ENTRIES(ENTRIES), .UP_W(UP_ID_W), .MAX_TXN(MAX_TXN),
        .IDXW(IDXW), .CNTW(CNTW)
    ) i_wtab (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_id     (s_aw_id),
        .match_vec(w_match),
        .free_vec (w_free),
        .sat_vec  (w_sat),
        .push_en  (aw_fire),
        .push_idx (aw_idx),
        .push_id  (s_aw_id),
        .pop_en   (wt_pop_en),
        .pop_idx  (m_b_id[IDXW-1:0]),
        .pop_up_id(wt_up_id)
    );

    idr_table #(
        .ENTRIES(ENTRIES), .UP_W(UP_ID_W), .MAX_TXN(MAX_TXN),
        .IDXW(IDXW), .CNTW(CNTW)
    ) i_rtab (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_id     (rt_q_id),
        .match_vec(r_match),
        .free_vec (r_free),
        .sat_vec  (r_sat),
        .push_en  (rt_push_en),
        .push_idx (rt_push_idx),
        .push_id  (rt_push_id),
        .pop_en   (rt_pop_en),
        .pop_idx  (m_r_id[IDXW-1:0]),
        .pop_up_id(rt_up_id)
    );

    idr_pick #(.N(ENTRIES), .IDXW(IDXW)) i_pick_wm (.req(w_match),   .idx(wm_idx), .any(w_hit));
    idr_pick #(.N(ENTRIES), .IDXW(IDXW)) i_pick_wf (.req(w_free),    .idx(wf_idx), .any(w_any_free));
    idr_pick #(.N(ENTRIES), .IDXW(IDXW)) i_pick_rm (.req(r_match),   .idx(rm_idx), .any(r_hit));
    idr_pick #(.N(ENTRIES), .IDXW(IDXW)) i_pick_rf (.req(r_free),    .idx(rf_idx), .any(r_any_free));
    idr_pick #(.N(ENTRIES), .IDXW(IDXW)) i_pick_bf (.req(both_free), .idx(bf_idx), .any(b_any_free));

    // plain write: reuse a live entry or take the lowest free one
    always_comb begin
        w_idx = w_hit ? wm_idx : wf_idx;
        w_ok  = w_hit ? !w_sat[wm_idx] : w_any_free;
    end

    // atomic write: one index that both tables accept
    always_comb begin
        if (w_hit)      a_idx = wm_idx;
        else if (r_hit) a_idx = rm_idx;
        else            a_idx = bf_idx;
        a_ok = (w_hit ? !w_sat[a_idx] : w_free[a_idx])
            && (r_hit ? (r_match[a_idx] && !r_sat[a_idx]) : r_free[a_idx])
            && (w_hit || r_hit || b_any_free);
    end

    // read: blocked while an atomic write owns the read table query
    always_comb begin
        r_idx = r_hit ? rm_idx : rf_idx;
        r_ok  = (r_hit ? !r_sat[rm_idx] : r_any_free) && !aw_atom_req;
    end

    assign aw_idx  = aw_atom ? a_idx : w_idx;
    assign aw_ok   = aw_atom ? a_ok  : w_ok;
    assign aw_fire = s_aw_valid && m_aw_ready && aw_ok;
    assign ar_fire = s_ar_valid && m_ar_ready && r_ok;

    assign rt_push_en  = (aw_fire && aw_atom) || ar_fire;
    assign rt_push_idx = aw_atom_req ? a_idx : r_idx;
    assign rt_push_id  = aw_atom_req ? s_aw_id : s_ar_id;

    assign wt_pop_en = m_b_valid && s_b_ready;
    assign rt_pop_en = m_r_valid && s_r_ready && m_r_last;

    // write address channel
    assign m_aw_valid = s_aw_valid && aw_ok;
    assign s_aw_ready = m_aw_ready && aw_ok;
    assign m_aw_id    = DN_ID_W'(aw_idx);
    assign m_aw_addr  = s_aw_addr;
    assign m_aw_len   = s_aw_len;
    assign m_aw_atop  = s_aw_atop;

    // write data channel
    assign m_w_valid = s_w_valid;
    assign s_w_ready = m_w_ready;
    assign m_w_data  = s_w_data;
    assign m_w_last  = s_w_last;

    // write response channel
    assign s_b_valid = m_b_valid;
    assign m_b_ready = s_b_ready;
    assign s_b_id    = wt_up_id;
    assign s_b_resp  = m_b_resp;

    // read address channel
    assign m_ar_valid = s_ar_valid && r_ok;
    assign s_ar_ready = m_ar_ready && r_ok;
    assign m_ar_id    = DN_ID_W'(r_idx);
    assign m_ar_addr  = s_ar_addr;
    assign m_ar_len   = s_ar_len;

    // read data channel
    assign s_r_valid = m_r_valid;
    assign m_r_ready = s_r_ready;
    assign s_r_id    = rt_up_id;
    assign s_r_data  = m_r_data;
    assign s_r_resp  = m_r_resp;
    assign s_r_last  = m_r_last;

endmodule

// File: rtl/idr_remap_chk.sv
module idr_remap_chk #(
    parameter int UP_ID_W = 6,
    parameter int DN_ID_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s_aw_valid,
    input logic               s_aw_ready,
    input logic [UP_ID_W-1:0] s_aw_id,
    input logic [5:0]         s_aw_atop,
    input logic               m_aw_valid,
    input logic               m_aw_ready,
    input logic               s_ar_valid,
    input logic               s_ar_ready,
    input logic               m_ar_valid,
    input logic               m_ar_ready,
    input logic               m_b_valid,
    input logic               m_b_ready,
    input logic [DN_ID_W-1:0] m_b_id,
    input logic               s_b_ready,
    input logic [UP_ID_W-1:0] s_b_id,
    input logic               m_r_valid,
    input logic               m_r_last,
    input logic               s_r_ready
);

    logic               stall_q, pop_q;
    logic [UP_ID_W-1:0] id_q;
    logic [5:0]         atop_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            pop_q   <= 1'b0;
            id_q    <= '0;
            atop_q  <= '0;
        end else begin
            stall_q <= s_aw_valid && !m_aw_valid;
            pop_q   <= (m_b_valid && s_b_ready) || (m_r_valid && s_r_ready && m_r_last);
            id_q    <= s_aw_id;
            atop_q  <= s_aw_atop;
        end
    end

    // R12: an accepted upstream request is a completed downstream handshake
    assert_aw_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_aw_valid && s_aw_ready) |-> (m_aw_valid && m_aw_ready));

    assert_ar_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ar_valid && s_ar_ready) |-> (m_ar_valid && m_ar_ready));

    // R10: a read-data atomic write keeps reads off the downstream port
    assert_atomic_holds_ar_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_aw_valid && s_aw_atop[5]) |-> !m_ar_valid);

    // R6 / R7: a stall only lifts after some response retired a transaction
    assert_stall_needs_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_q && s_aw_valid && s_aw_id == id_q && s_aw_atop == atop_q && !pop_q)
        |-> !m_aw_valid);

    // R4: a waiting response keeps its restored ID
    assert_b_id_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(m_b_valid && !m_b_ready) && m_b_valid && $stable(m_b_id)) |-> $stable(s_b_id));

endmodule

bind idr_remap idr_remap_chk #(
    .UP_ID_W(UP_ID_W),
    .DN_ID_W(DN_ID_W)
) i_idr_remap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_aw_valid(s_aw_valid),
    .s_aw_ready(s_aw_ready),
    .s_aw_id   (s_aw_id),
    .s_aw_atop (s_aw_atop),
    .m_aw_valid(m_aw_valid),
    .m_aw_ready(m_aw_ready),
    .s_ar_valid(s_ar_valid),
    .s_ar_ready(s_ar_ready),
    .m_ar_valid(m_ar_valid),
    .m_ar_ready(m_ar_ready),
    .m_b_valid (m_b_valid),
    .m_b_ready (m_b_ready),
    .m_b_id    (m_b_id),
    .s_b_ready (s_b_ready),
    .s_b_id    (s_b_id),
    .m_r_valid (m_r_valid),
    .m_r_last  (m_r_last),
    .s_r_ready (s_r_ready)
);

// File: tb/test_idr_remap.sv
module test_idr_remap;

    localparam int CLK_PERIOD = 10;
    localparam int UP_ID_W = 6;
    localparam int DN_ID_W = 2;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int LEN_W   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic               s_aw_valid = 0, s_aw_ready;
    logic [UP_ID_W-1:0] s_aw_id = '0;
    logic [ADDR_W-1:0]  s_aw_addr = '0;
    logic [LEN_W-1:0]   s_aw_len = '0;
    logic [5:0]         s_aw_atop = '0;
    logic               m_aw_valid, m_aw_ready = 1;
    logic [DN_ID_W-1:0] m_aw_id;
    logic [ADDR_W-1:0]  m_aw_addr;
    logic [LEN_W-1:0]   m_aw_len;
    logic [5:0]         m_aw_atop;
    logic               s_w_valid = 0, s_w_ready;
    logic [DATA_W-1:0]  s_w_data = '0;
    logic               s_w_last = 0;
    logic               m_w_valid, m_w_ready = 1;
    logic [DATA_W-1:0]  m_w_data;
    logic               m_w_last;
    logic               m_b_valid = 0, m_b_ready;
    logic [DN_ID_W-1:0] m_b_id = '0;
    logic [1:0]         m_b_resp = '0;
    logic               s_b_valid, s_b_ready = 1;
    logic [UP_ID_W-1:0] s_b_id;
    logic [1:0]         s_b_resp;
    logic               s_ar_valid = 0, s_ar_ready;
    logic [UP_ID_W-1:0] s_ar_id = '0;
    logic [ADDR_W-1:0]  s_ar_addr = '0;
    logic [LEN_W-1:0]   s_ar_len = '0;
    logic               m_ar_valid, m_ar_ready = 1;
    logic [DN_ID_W-1:0] m_ar_id;
    logic [ADDR_W-1:0]  m_ar_addr;
    logic [LEN_W-1:0]   m_ar_len;
    logic               m_r_valid = 0, m_r_ready;
    logic [DN_ID_W-1:0] m_r_id = '0;
    logic [DATA_W-1:0]  m_r_data = '0;
    logic [1:0]         m_r_resp = '0;
    logic               m_r_last = 0;
    logic               s_r_valid, s_r_ready = 1;
    logic [UP_ID_W-1:0] s_r_id;
    logic [DATA_W-1:0]  s_r_data;
    logic [1:0]         s_r_resp;
    logic               s_r_last;

    int n_checks = 0;
    int n_fail   = 0;

    idr_remap i_idr_remap (.*);

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one write address cycle; exp_ok says whether it may go out
    task automatic aw_try(input logic [UP_ID_W-1:0] id, input logic [5:0] atop,
                          input logic exp_ok, input logic [DN_ID_W-1:0] exp_dn, input string req);
        @(negedge clk);
        s_aw_valid = 1; s_aw_id = id; s_aw_atop = atop; s_aw_addr = {10'h0, id};
        #1;
        chk(m_aw_valid == exp_ok && s_aw_ready == exp_ok, req, {m_aw_valid, s_aw_ready}, {exp_ok, exp_ok});
        if (exp_ok) chk(m_aw_id == exp_dn && m_aw_addr == {10'h0, id}, req, m_aw_id, exp_dn);
        @(posedge clk); #1;
        s_aw_valid = 0; s_aw_atop = '0;
    endtask

    task automatic ar_try(input logic [UP_ID_W-1:0] id, input logic exp_ok,
                          input logic [DN_ID_W-1:0] exp_dn, input string req);
        @(negedge clk);
        s_ar_valid = 1; s_ar_id = id;
        #1;
        chk(m_ar_valid == exp_ok && s_ar_ready == exp_ok, req, {m_ar_valid, s_ar_ready}, {exp_ok, exp_ok});
        if (exp_ok) chk(m_ar_id == exp_dn, req, m_ar_id, exp_dn);
        @(posedge clk); #1;
        s_ar_valid = 0;
    endtask

    task automatic b_ret(input logic [DN_ID_W-1:0] dn, input logic [UP_ID_W-1:0] exp_up, input string req);
        @(negedge clk);
        m_b_valid = 1; m_b_id = dn; m_b_resp = 2'b10;
        #1;
        chk(s_b_valid && s_b_id == exp_up && s_b_resp == 2'b10, req, s_b_id, exp_up);
        @(posedge clk); #1;
        m_b_valid = 0;
    endtask

    task automatic r_ret(input logic [DN_ID_W-1:0] dn, input logic last,
                         input logic [UP_ID_W-1:0] exp_up, input string req);
        @(negedge clk);
        m_r_valid = 1; m_r_id = dn; m_r_last = last; m_r_data = {26'h0, exp_up} ^ 32'hA5A5_0000;
        #1;
        chk(s_r_valid && s_r_id == exp_up && s_r_last == last, req, s_r_id, exp_up);
        chk(s_r_data == ({26'h0, exp_up} ^ 32'hA5A5_0000), req, s_r_data, {26'h0, exp_up} ^ 32'hA5A5_0000);
        @(posedge clk); #1;
        m_r_valid = 0; m_r_last = 0;
    endtask

    // request held while a B retires in the stall cycle; goes out the cycle after
    task automatic aw_stall_release(input logic [UP_ID_W-1:0] id, input logic [DN_ID_W-1:0] b_dn,
                                    input logic [UP_ID_W-1:0] b_up, input logic [DN_ID_W-1:0] exp_dn,
                                    input string req);
        @(negedge clk);
        s_aw_valid = 1; s_aw_id = id; s_aw_atop = '0;
        m_b_valid = 1; m_b_id = b_dn;
        #1;
        chk(!m_aw_valid && !s_aw_ready, req, {m_aw_valid, s_aw_ready}, 2'b00);
        chk(s_b_id == b_up, req, s_b_id, b_up);
        @(posedge clk); #1;
        m_b_valid = 0;
        @(negedge clk); #1;
        chk(m_aw_valid && s_aw_ready && m_aw_id == exp_dn, req, m_aw_id, exp_dn);
        @(posedge clk); #1;
        s_aw_valid = 0;
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk(!m_aw_valid && !m_ar_valid && !s_b_valid && !s_r_valid, "R1",
            {m_aw_valid, m_ar_valid, s_b_valid, s_r_valid}, 0);
        aw_try(6'h0C, 6'h00, 1, 0, "R1");
        b_ret(0, 6'h0C, "R1");
    endtask

    task automatic t_alloc;
        aw_try(6'h15, 6'h00, 1, 0, "R2");
        aw_try(6'h2A, 6'h00, 1, 1, "R2");
        aw_try(6'h15, 6'h00, 1, 0, "R3");
        b_ret(0, 6'h15, "R4");
        aw_try(6'h33, 6'h00, 1, 2, "R3");
        b_ret(0, 6'h15, "R5");
        aw_try(6'h07, 6'h00, 1, 0, "R5");
        b_ret(1, 6'h2A, "R4");
        b_ret(2, 6'h33, "R4");
        b_ret(0, 6'h07, "R4");
    endtask

    task automatic t_limit;
        for (int k = 0; k < 3; k++) aw_try(6'h11, 6'h00, 1, 0, "R6");
        aw_try(6'h11, 6'h00, 0, 0, "R6");
        aw_stall_release(6'h11, 0, 6'h11, 0, "R6");
        for (int k = 0; k < 3; k++) b_ret(0, 6'h11, "R6");
    endtask

    task automatic t_full;
        for (int k = 0; k < 4; k++) aw_try(UP_ID_W'(k + 1), 6'h00, 1, DN_ID_W'(k), "R7");
        aw_try(6'h05, 6'h00, 0, 0, "R7");
        aw_stall_release(6'h05, 2, 6'h03, 2, "R7");
        b_ret(0, 6'h01, "R7");
        b_ret(1, 6'h02, "R7");
        b_ret(2, 6'h05, "R7");
        b_ret(3, 6'h04, "R7");
    endtask

    task automatic t_read;
        aw_try(6'h15, 6'h00, 1, 0, "R8");
        ar_try(6'h20, 1, 0, "R8");
        ar_try(6'h21, 1, 1, "R8");
        ar_try(6'h20, 1, 0, "R8");
        r_ret(0, 0, 6'h20, "R5");
        r_ret(0, 1, 6'h20, "R5");
        ar_try(6'h22, 1, 2, "R5");
        r_ret(0, 1, 6'h20, "R5");
        ar_try(6'h23, 1, 0, "R8");
        r_ret(1, 1, 6'h21, "R4");
        r_ret(2, 1, 6'h22, "R4");
        r_ret(0, 1, 6'h23, "R4");
        b_ret(0, 6'h15, "R8");
    endtask

    task automatic t_atomic;
        ar_try(6'h30, 1, 0, "R9");
        // atomic write and a read request raised together
        @(negedge clk);
        s_aw_valid = 1; s_aw_id = 6'h31; s_aw_atop = 6'h20;
        s_ar_valid = 1; s_ar_id = 6'h32;
        #1;
        chk(m_aw_valid && m_aw_id == 1, "R9", m_aw_id, 1);
        chk(!m_ar_valid && !s_ar_ready, "R10", {m_ar_valid, s_ar_ready}, 0);
        @(posedge clk); #1;
        s_aw_valid = 0; s_aw_atop = '0; s_ar_valid = 0;
        aw_try(6'h31, 6'h00, 1, 1, "R9");
        r_ret(1, 1, 6'h31, "R9");
        b_ret(1, 6'h31, "R9");
        b_ret(1, 6'h31, "R9");
        r_ret(0, 1, 6'h30, "R9");
        // read table full: atomic load stalls, atomic store does not
        for (int k = 0; k < 4; k++) ar_try(UP_ID_W'(6'h40 + k), 1, DN_ID_W'(k), "R9");
        aw_try(6'h44, 6'h20, 0, 0, "R9");
        aw_try(6'h45, 6'h10, 1, 0, "R9");
        for (int k = 0; k < 4; k++) r_ret(DN_ID_W'(k), 1, UP_ID_W'(6'h40 + k), "R9");
        aw_try(6'h44, 6'h20, 1, 1, "R9");
        b_ret(0, 6'h45, "R9");
        b_ret(1, 6'h44, "R9");
        r_ret(1, 1, 6'h44, "R9");
    endtask

    task automatic t_wpass;
        @(negedge clk);
        s_w_valid = 1; s_w_data = 32'hDEAD_BEEF; s_w_last = 1; m_w_ready = 1;
        #1;
        chk(m_w_valid && m_w_last && m_w_data == 32'hDEAD_BEEF && s_w_ready, "R11", m_w_data, 32'hDEAD_BEEF);
        m_w_ready = 0;
        #1;
        chk(!s_w_ready, "R11", s_w_ready, 0);
        @(posedge clk); #1;
        s_w_valid = 0; s_w_last = 0; m_w_ready = 1;
    endtask

    task automatic t_ready_gate;
        m_aw_ready = 0;
        @(negedge clk);
        s_aw_valid = 1; s_aw_id = 6'h3F; s_aw_atop = '0;
        #1;
        chk(m_aw_valid && !s_aw_ready, "R12", {m_aw_valid, s_aw_ready}, 2'b10);
        @(posedge clk); #1;
        s_aw_valid = 0; m_aw_ready = 1;
        aw_try(6'h3F, 6'h00, 1, 0, "R12");
        b_ret(0, 6'h3F, "R12");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_alloc();
        t_limit();
        t_full();
        t_read();
        t_atomic();
        t_wpass();
        t_ready_gate();
        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule